// File: doc/BRIEF.md
# Width-adapting unpack FIFO

This block sits between a bus side and a local side. The bus side delivers data beats that are either 64 or 32 bits wide. The local side always takes 32-bit words, each carrying four active-low byte enables. Every storage entry is 64 data bits plus 8 active-low byte enables, whatever the beat width. A 64-bit beat fills one whole entry as it arrives. A 32-bit beat is steered into the low or high half of an entry by address bit 2. Any half that no beat fills becomes a dummy word: its data is undefined and all its byte enables are deasserted (4'b1111).

The write path is controlled by a two-state packer machine:
- `PK_IDLE` means no half entry is pending.
- An accepted 32-bit beat with bit 2 clear and without the last flag moves it to `PK_LOW`, holding that beat.
- The next accepted beat completes the entry, fills the high half and returns the machine to `PK_IDLE`.

The read path is a two-state lane machine:
- `RD_LOW` presents the low half of the head entry.
- A handshake on that word moves it to `RD_HIGH`, which presents the high half.
- A handshake on the high word pops the entry and returns the machine to `RD_LOW`.

The write side is stalled through `wr_ready` when storage is full, so no beat is ever dropped.

Top module: `wunp_fifo`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `rd_valid`=0 and `wr_ready`=1.
- R2: An accepted 64-bit beat (`wr_wide`=1) yields two read words: first `{wr_be_n[3:0], wr_data[31:0]}`, then `{wr_be_n[7:4], wr_data[63:32]}`. In each read word the byte enables sit in `rd_data[35:32]` and the data in `rd_data[31:0]`.
- R3: A 64-bit beat is only offered with `wr_addr2`=0.
- R4: A 32-bit beat with `wr_addr2`=0 and `wr_last`=0 is held back and emits no read word yet. It is read out first, directly followed by the low 32 data bits and low 4 byte enables of the next accepted beat.
- R5: A 32-bit beat accepted with `wr_addr2`=1 while no half entry is pending yields a dummy word (`rd_data[35:32]`=4'b1111), then the beat's own word.
- R6: A 32-bit beat accepted with `wr_addr2`=0 and `wr_last`=1 while no half entry is pending yields the beat's word, then a dummy word.
- R7: `full` is 1 exactly when DEPTH entries are stored. `wr_ready` equals `!full`, and every beat offered while full is accepted later without loss.
- R8: While `rd_valid`=1 and `rd_ready`=0, `rd_valid` and `rd_data` hold their values into the next cycle.
- R9: `rd_valid` = `!empty`. Both reflect a completed entry in the cycle right after the edge that accepted its final beat.
- R10: `full` and `empty` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Bus beat offered |
| wr_ready | output | 1 | Beat accepted this cycle when high with wr_valid |
| wr_wide | input | 1 | 1: 64-bit beat, 0: 32-bit beat in bits [31:0] |
| wr_addr2 | input | 1 | Address bit 2 of the beat |
| wr_last | input | 1 | Final beat of the burst |
| wr_data | input | 64 | Beat data |
| wr_be_n | input | 8 | Beat byte enables, active-low |
| full | output | 1 | DEPTH entries stored |
| empty | output | 1 | No entry stored |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Local side takes the word |
| rd_data | output | 36 | {byte enables active-low, 32 data bits} |

## Verification
The last beat of an entry is accepted on a rising edge. `empty`, `full` and `rd_valid` change right after that edge, and the bench expects them at the next falling edge. The word shown on `rd_data` changes one edge after each read handshake. A behavioural queue of expected words is updated just after each rising edge from the beats and handshakes the bench drove, and all outputs are compared with it at every falling edge. Dummy words are checked on their byte enables only, since their data is undefined.

// File: rtl/wunp_pkg.sv
package wunp_pkg;
    typedef enum logic {PK_IDLE, PK_LOW} pk_state_t;
    typedef enum logic {RD_LOW, RD_HIGH} rd_state_t;
endpackage

// File: rtl/wunp_packer.sv
module wunp_packer
    import wunp_pkg::*;
#(
    parameter int HALF_W = 32,
    localparam int BEW = HALF_W / 8,
    localparam int ENTRY_W = 2 * (HALF_W + BEW)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    output logic                 wr_ready,
    input  logic                 wr_wide,
    input  logic                 wr_addr2,
    input  logic                 wr_last,
    input  logic [2*HALF_W-1:0]  wr_data,
    input  logic [2*BEW-1:0]     wr_be_n,
    input  logic                 store_full,
    output logic                 push,
    output logic [ENTRY_W-1:0]   push_data
);
    localparam logic [BEW-1:0]    BE_OFF = {BEW{1'b1}};
    localparam logic [HALF_W-1:0] D_NONE = {HALF_W{1'b0}};

    pk_state_t        state, state_nxt;
    logic [HALF_W-1:0] held_d;
    logic [BEW-1:0]    held_be;
    logic              capture;
    logic              fire;

    assign wr_ready = !store_full;
    assign fire     = wr_valid && wr_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= PK_IDLE;
            held_d  <= '0;
            held_be <= BE_OFF;
        end else begin
            state <= state_nxt;
            if (capture) begin
                held_d  <= wr_data[HALF_W-1:0];
                held_be <= wr_be_n[BEW-1:0];
            end
        end
    end

    // entry layout: {be_n_hi, be_n_lo, data_hi, data_lo}
    always_comb begin
        state_nxt = state;
        push      = 1'b0;
        capture   = 1'b0;
        push_data = '0;
        unique case (state)
            PK_IDLE: begin
                if (fire) begin
                    if (wr_wide) begin
                        push      = 1'b1;
                        push_data = {wr_be_n, wr_data};
                    end else if (wr_addr2) begin
                        push      = 1'b1;
                        push_data = {wr_be_n[BEW-1:0], BE_OFF, wr_data[HALF_W-1:0], D_NONE};
                    end else if (wr_last) begin
                        push      = 1'b1;
                        push_data = {BE_OFF, wr_be_n[BEW-1:0], D_NONE, wr_data[HALF_W-1:0]};
                    end else begin
                        capture   = 1'b1;
                        state_nxt = PK_LOW;
                    end
                end
            end
            PK_LOW: begin
                if (fire) begin
                    push      = 1'b1;
                    push_data = {wr_be_n[BEW-1:0], held_be, wr_data[HALF_W-1:0], held_d};
                    state_nxt = PK_IDLE;
                end
            end
        endcase
    end

    // R3: wide beats must be quadword aligned
    p_wide_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_wide) |-> !wr_addr2);

    // R7: nothing is committed into a full store
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !store_full);
endmodule

// File: rtl/wunp_store.sv
module wunp_store #(
    parameter int ENTRY_W = 72,
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic [ENTRY_W-1:0] push_data,
    input  logic               pop,
    output logic [ENTRY_W-1:0] head,
    output logic               full,
    output logic               empty
);
    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [AW:0]        wptr, rptr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wptr[AW-1:0]] <= push_data;
    end

    assign head  = mem[rptr[AW-1:0]];
    assign empty = (wptr == rptr);
    assign full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);

    // R9: no pop without a stored entry
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R9: a lone commit makes the store non-empty on the next cycle
    p_push_shows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> !empty);

    // R10
    p_full_empty_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

// File: rtl/wunp_reader.sv
module wunp_reader
    import wunp_pkg::*;
#(
    parameter int HALF_W = 32,
    localparam int BEW = HALF_W / 8,
    localparam int ENTRY_W = 2 * (HALF_W + BEW),
    localparam int WORD_W = HALF_W + BEW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRY_W-1:0] head,
    input  logic               empty,
    output logic               rd_valid,
    input  logic               rd_ready,
    output logic [WORD_W-1:0]  rd_data,
    output logic               pop
);
    rd_state_t state, state_nxt;
    logic      take;

    assign take = rd_valid && rd_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RD_LOW;
        else        state <= state_nxt;
    end

    always_comb begin
        rd_valid  = !empty;
        state_nxt = state;
        pop       = 1'b0;
        rd_data   = '0;
        unique case (state)
            RD_LOW: begin
                rd_data = {head[2*HALF_W +: BEW], head[0 +: HALF_W]};
                if (take) state_nxt = RD_HIGH;
            end
            RD_HIGH: begin
                rd_data = {head[2*HALF_W+BEW +: BEW], head[HALF_W +: HALF_W]};
                if (take) begin
                    pop       = 1'b1;
                    state_nxt = RD_LOW;
                end
            end
        endcase
    end

    // R8: a stalled word is held
    p_hold_stalled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: rtl/wunp_fifo.sv
module wunp_fifo #(
    parameter int DEPTH = 8,
    parameter int HALF_W = 32,
    localparam int BEW = HALF_W / 8,
    localparam int ENTRY_W = 2 * (HALF_W + BEW)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    output logic                wr_ready,
    input  logic                wr_wide,
    input  logic                wr_addr2,
    input  logic                wr_last,
    input  logic [2*HALF_W-1:0] wr_data,
    input  logic [2*BEW-1:0]    wr_be_n,
    output logic                full,
    output logic                empty,
    output logic                rd_valid,
    input  logic                rd_ready,
    output logic [HALF_W+BEW-1:0] rd_data
);
    logic               push, pop;
    logic [ENTRY_W-1:0] push_data, head;

    wunp_packer #(.HALF_W(HALF_W)) u_packer (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_wide(wr_wide),
        .wr_addr2(wr_addr2), .wr_last(wr_last), .wr_data(wr_data),
        .wr_be_n(wr_be_n), .store_full(full),
        .push(push), .push_data(push_data)
    );

    wunp_store #(.ENTRY_W(ENTRY_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_data(push_data), .pop(pop),
        .head(head), .full(full), .empty(empty)
    );

    wunp_reader #(.HALF_W(HALF_W)) u_reader (
        .clk(clk), .rst_n(rst_n),
        .head(head), .empty(empty),
        .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_data(rd_data), .pop(pop)
    );

    // R9: read side validity follows storage occupancy
    p_valid_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == !empty);
endmodule

// File: tb/test_wunp_fifo.sv
module test_wunp_fifo;
    localparam int DEPTH = 8;
    localparam int MAXCYC = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0, wr_wide = 1'b0, wr_addr2 = 1'b0, wr_last = 1'b0;
    logic [63:0] wr_data = '0;
    logic [7:0]  wr_be_n = '0;
    logic        rd_ready = 1'b0;
    logic        wr_ready, full, empty, rd_valid;
    logic [35:0] rd_data;

    always #10 clk = ~clk;

    wunp_fifo #(.DEPTH(DEPTH), .HALF_W(32)) i_wunp_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_wide(wr_wide),
        .wr_addr2(wr_addr2), .wr_last(wr_last), .wr_data(wr_data),
        .wr_be_n(wr_be_n), .full(full), .empty(empty),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data)
    );

    int checks = 0, failures = 0, cycles = 0;
    bit hung = 0;
    int rd_mode = 0;   // 0 always ready, 1 never, 2 random
    int wr_mode = 0;   // 0 always offer, 1 random gaps

    // stimulus queues
    bit          s_w[$], s_a[$], s_l[$];
    logic [63:0] s_d[$];
    logic [7:0]  s_b[$];

    // expected read words
    logic [35:0] q_v[$];
    bit          q_dum[$];
    string       q_tag[$];

    bit          m_hold = 0;
    logic [35:0] m_held;
    bit          prev_stall = 0;
    logic [35:0] prev_data;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic add_beat(input bit w, input bit a, input bit l);
        s_w.push_back(w); s_a.push_back(a); s_l.push_back(l);
        s_d.push_back({$urandom, $urandom});
        s_b.push_back(8'($urandom));
    endtask

    task automatic burst64(input int n);
        for (int i = 0; i < n; i++) add_beat(1'b1, 1'b0, i == n - 1);
    endtask

    task automatic burst32(input bit a0, input int n);
        bit a;
        a = a0;
        for (int i = 0; i < n; i++) begin
            add_beat(1'b0, a, i == n - 1);
            a = !a;
        end
    endtask

    task automatic push_exp(input logic [35:0] v, input bit d, input string t);
        q_v.push_back(v); q_dum.push_back(d); q_tag.push_back(t);
    endtask

    task automatic one_cycle();
        int entries;
        bit wfire, rfire;
        bit bw, ba, bl;
        logic [63:0] bd;
        logic [7:0] bb;
        @(negedge clk);
        cycles++;
        if (cycles > MAXCYC) begin
            hung = 1;
            chk(1'b0, "WATCHDOG", 64'(cycles), 64'(MAXCYC));
            return;
        end
        entries = (q_v.size() + 1) / 2;
        chk(rd_valid == (q_v.size() != 0), "R9 rd_valid", 64'(rd_valid), 64'(q_v.size() != 0));
        chk(empty == (q_v.size() == 0), "R9 empty", 64'(empty), 64'(q_v.size() == 0));
        chk(full == (entries == DEPTH), "R7 full", 64'(full), 64'(entries == DEPTH));
        chk(wr_ready == (entries != DEPTH), "R7 wr_ready", 64'(wr_ready), 64'(entries != DEPTH));
        chk(!(full && empty), "R10", {full, empty}, 64'd0);
        if (prev_stall)
            chk(rd_valid && rd_data == prev_data, "R8 hold", 64'(rd_data), 64'(prev_data));
        if (rd_valid && q_v.size() != 0) begin
            if (q_dum[0])
                chk(rd_data[35:32] == 4'hF, {q_tag[0], " dummy"}, 64'(rd_data), 64'(q_v[0]));
            else
                chk(rd_data == q_v[0], q_tag[0], 64'(rd_data), 64'(q_v[0]));
        end
        // drive
        case (rd_mode)
            0: rd_ready = 1'b1;
            1: rd_ready = 1'b0;
            default: rd_ready = 1'($urandom);
        endcase
        wr_valid = (s_w.size() != 0) && (wr_mode == 0 || ($urandom % 3) != 0);
        if (s_w.size() != 0) begin
            wr_wide = s_w[0]; wr_addr2 = s_a[0]; wr_last = s_l[0];
            wr_data = s_d[0]; wr_be_n = s_b[0];
        end
        bw = wr_wide; ba = wr_addr2; bl = wr_last; bd = wr_data; bb = wr_be_n;
        wfire = wr_valid && wr_ready;
        rfire = rd_valid && rd_ready;
        prev_stall = rd_valid && !rd_ready;
        prev_data = rd_data;
        @(posedge clk);
        if (rfire) begin
            void'(q_v.pop_front()); void'(q_dum.pop_front()); void'(q_tag.pop_front());
        end
        if (wfire) begin
            void'(s_w.pop_front()); void'(s_a.pop_front()); void'(s_l.pop_front());
            void'(s_d.pop_front()); void'(s_b.pop_front());
            if (m_hold) begin
                push_exp(m_held, 0, "R4 held");
                push_exp({bb[3:0], bd[31:0]}, 0, "R4 high");
                m_hold = 0;
            end else if (bw) begin
                push_exp({bb[3:0], bd[31:0]}, 0, "R2 low");
                push_exp({bb[7:4], bd[63:32]}, 0, "R2 high");
            end else if (ba) begin
                push_exp({4'hF, 32'h0}, 1, "R5");
                push_exp({bb[3:0], bd[31:0]}, 0, "R5 beat");
            end else if (bl) begin
                push_exp({bb[3:0], bd[31:0]}, 0, "R6 beat");
                push_exp({4'hF, 32'h0}, 1, "R6");
            end else begin
                m_hold = 1;
                m_held = {bb[3:0], bd[31:0]};
            end
        end
    endtask

    task automatic run_idle();
        while (!hung && (s_w.size() != 0 || q_v.size() != 0 || m_hold)) one_cycle();
    endtask

    task automatic run_n(input int n);
        for (int i = 0; i < n && !hung; i++) one_cycle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(empty == 1'b1, "R1 empty", 64'(empty), 64'd1);
        chk(full == 1'b0, "R1 full", 64'(full), 64'd0);
        chk(rd_valid == 1'b0, "R1 rd_valid", 64'(rd_valid), 64'd0);
        chk(wr_ready == 1'b1, "R1 wr_ready", 64'(wr_ready), 64'd1);
        @(posedge clk);

        // R2 wide burst
        rd_mode = 0; wr_mode = 0;
        burst64(4);
        run_idle();
        // R4 aligned even narrow burst
        burst32(1'b0, 4);
        run_idle();
        // R5 misaligned start
        burst32(1'b1, 3);
        run_idle();
        // R6 aligned odd end
        burst32(1'b0, 3);
        run_idle();
        // R7/R8 fill with reader stalled
        rd_mode = 1;
        burst64(10);
        run_n(30);
        chk(full == 1'b1 && wr_ready == 1'b0, "R7 stalled", {full, wr_ready}, 64'd2);
        rd_mode = 0;
        run_idle();
        // mixed traffic
        rd_mode = 2; wr_mode = 1;
        for (int k = 0; k < 40; k++) begin
            if ($urandom % 3 == 0) burst64(1 + $urandom % 4);
            else burst32(1'($urandom), 1 + $urandom % 6);
        end
        run_idle();
        rd_mode = 0;
        run_n(3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule